// File: doc/BRIEF.md
# Prioritized Interrupt Controller, 64 Sources

The block collects 64 level-sensitive interrupt request lines and presents one interrupt to a processor as a priority level and a vector number. The pending register samples each request line on every clock. Each source has a byte-wide priority setting. A non-zero byte also enables the source. A per-source mask register blocks a source. A forced-request register is also part of the active test, and in this version it always reads as zero.

On each clock the controller finds the active source with the largest priority byte. If several active sources share that byte, the one with the highest source number wins. The level and vector of that source are registered onto the processor outputs. When no source is active, the level is zero and the vector is 24. Software reaches the registers over a simple synchronous bus. Read data is returned one cycle after the request. Writes to offsets that cannot be written raise a one-cycle error pulse.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Pending bit n follows request input n. It is captured on each clock. Offset 0x00 reads sources 63..32 (source 32 at bit 0) and offset 0x04 reads sources 31..0 (source 0 at bit 0).
- R2: A source is active only when it is (pending OR forced) AND enabled AND NOT masked. A masked or disabled source never drives the outputs.
- R3: Offsets 0x40+n (n = 0..63) hold the priority byte of source n in bits 7:0. Writing a zero byte disables the source and writing a non-zero byte enables it. Reads return the byte zero-extended.
- R4: The winner is the active source with the largest priority byte. When several active sources share that byte, the highest source number wins.
- R5: The vector output is the winning source number plus 64. With no active source the vector is 24 and the level is 0.
- R6: The level output equals the priority byte of the winning source.
- R7: Offset 0x08 holds mask bits for sources 63..32 and offset 0x0C holds those for sources 31..0 (a 1 masks the source). A write replaces only the addressed half, and reads return it.
- R8: Writes to 0x00 and 0x04 change nothing and raise no error. A write to any other offset that is not a mask or priority offset changes nothing and pulses bus_err for one cycle. This includes the force offsets 0x10/0x14 and 0xE0.
- R9: Reads of the force offsets 0x10/0x14 return zero, and reads of any unmapped offset return zero.
- R10: A read of offset 0xE0 returns the current registered vector in bits 7:0.
- R11: bus_rvalid is high, with bus_rdata valid, exactly in the cycle after a cycle with bus_re high.
- R12: While reset is asserted, and after reset until the first write: mask all ones, pending and enables zero, every priority byte zero, level 0, vector 24.
- R13: Level and vector are registered. A register write changes them one clock edge after the write edge. A request input change shows on them two edges after it is driven: one edge to capture it and one to register the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | 64 | Level-sensitive request lines, one per source |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_re | input | 1 | Read strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_re |
| bus_err | output | 1 | One-cycle pulse after a write to a non-writable offset |
| cpu_level | output | 8 | Priority level presented to the processor |
| cpu_vector | output | 8 | Vector number presented to the processor |

## Verification
Two things can land in the same cycle: a register write that changes which source wins, and a change on a request line that arrives while that write is still settling. Priority and mask writes are made while several sources are already pending, so the arbitration result moves as a direct effect of the bus. The bench compares level and vector one edge after each write and two edges after each request change. It also samples one edge early, where the old value must still be present. Ties are provoked at both ends of the source range (sources 0 and 63, and sources 5 and 40), and the winner is judged by the vector number.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_NSRC     = 64;
  localparam int unsigned IRQ_PRIO_W   = 8;
  localparam int unsigned IRQ_DATA_W   = 32;
  localparam int unsigned IRQ_ADDR_W   = 8;
  localparam int unsigned IRQ_VEC_W    = 8;
  localparam int unsigned IRQ_VEC_BASE = 64;
  localparam int unsigned IRQ_VEC_IDLE = 24;

  // byte offsets on the register bus
  localparam logic [7:0] OFS_PEND_HI  = 8'h00;
  localparam logic [7:0] OFS_PEND_LO  = 8'h04;
  localparam logic [7:0] OFS_MASK_HI  = 8'h08;
  localparam logic [7:0] OFS_MASK_LO  = 8'h0C;
  localparam logic [7:0] OFS_FORCE_HI = 8'h10;
  localparam logic [7:0] OFS_FORCE_LO = 8'h14;
  localparam logic [7:0] OFS_PRIO     = 8'h40;
  localparam logic [7:0] OFS_SWACK    = 8'hE0;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC  = IRQ_NSRC,
  parameter int unsigned PRIO_W = IRQ_PRIO_W,
  parameter int unsigned DATA_W = IRQ_DATA_W,
  parameter int unsigned ADDR_W = IRQ_ADDR_W,
  parameter int unsigned VEC_W  = IRQ_VEC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        req,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_we,
  input  logic                    bus_re,
  input  logic [DATA_W-1:0]       bus_wdata,
  input  logic [VEC_W-1:0]        cur_vec,
  output logic [N_SRC-1:0]        pend,
  output logic [N_SRC-1:0]        mask,
  output logic [N_SRC-1:0]        frc,
  output logic [N_SRC-1:0]        enable,
  output logic [N_SRC*PRIO_W-1:0] prio_flat,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    bus_rvalid,
  output logic                    bus_err
);
  // the two halves of each wide register map one-to-one onto bus words
  localparam int unsigned HALF  = N_SRC / 2;
  localparam int unsigned IDX_W = $clog2(N_SRC);

  logic [N_SRC-1:0]  pend_q, pend_d;
  logic [N_SRC-1:0]  mask_q, mask_d;
  logic [PRIO_W-1:0] prio_q [N_SRC];
  logic              en_q   [N_SRC];
  logic [N_SRC-1:0]  prio_wr;

  logic              hit_prio;
  logic [IDX_W-1:0]  prio_sel;
  logic              hit_mask_hi, hit_mask_lo, hit_pend;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              rvalid_q, err_q, err_d;

  // ---------------- decode ----------------
  always_comb begin
    hit_prio    = (bus_addr >= ADDR_W'(OFS_PRIO)) &&
                  (bus_addr <  ADDR_W'(OFS_PRIO) + ADDR_W'(N_SRC));
    prio_sel    = IDX_W'(bus_addr - ADDR_W'(OFS_PRIO));
    hit_mask_hi = (bus_addr == ADDR_W'(OFS_MASK_HI));
    hit_mask_lo = (bus_addr == ADDR_W'(OFS_MASK_LO));
    hit_pend    = (bus_addr == ADDR_W'(OFS_PEND_HI)) ||
                  (bus_addr == ADDR_W'(OFS_PEND_LO));
  end

  // ---------------- pending and mask next state ----------------
  always_comb begin
    pend_d = req;
    mask_d = mask_q;
    if (bus_we && hit_mask_hi) mask_d[N_SRC-1:HALF] = HALF'(bus_wdata);
    if (bus_we && hit_mask_lo) mask_d[HALF-1:0]     = HALF'(bus_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
    end
  end

  // ---------------- per-source priority and enable ----------------
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic [PRIO_W-1:0] prio_d;
    logic              en_d;

    assign prio_wr[g] = bus_we && hit_prio && (prio_sel == IDX_W'(g));

    always_comb begin
      prio_d = prio_q[g];
      en_d   = en_q[g];
      if (prio_wr[g]) begin
        prio_d = bus_wdata[PRIO_W-1:0];
        en_d   = |bus_wdata[PRIO_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[g] <= '0;
        en_q[g]   <= 1'b0;
      end else begin
        prio_q[g] <= prio_d;
        en_q[g]   <= en_d;
      end
    end

    assign enable[g]                       = en_q[g];
    assign prio_flat[g*PRIO_W +: PRIO_W]   = prio_q[g];
  end

  // ---------------- read path ----------------
  always_comb begin
    rdata_d = '0;
    if (hit_prio) begin
      rdata_d = DATA_W'(prio_q[prio_sel]);
    end else begin
      case (bus_addr)
        ADDR_W'(OFS_PEND_HI): rdata_d = DATA_W'(pend_q[N_SRC-1:HALF]);
        ADDR_W'(OFS_PEND_LO): rdata_d = DATA_W'(pend_q[HALF-1:0]);
        ADDR_W'(OFS_MASK_HI): rdata_d = DATA_W'(mask_q[N_SRC-1:HALF]);
        ADDR_W'(OFS_MASK_LO): rdata_d = DATA_W'(mask_q[HALF-1:0]);
        ADDR_W'(OFS_SWACK):   rdata_d = DATA_W'(cur_vec);
        default:              rdata_d = '0;
      endcase
    end
    err_d = bus_we && !(hit_prio || hit_mask_hi || hit_mask_lo || hit_pend);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (bus_re) rdata_q <= rdata_d;
      rvalid_q <= bus_re;
      err_q    <= err_d;
    end
  end

  assign pend       = pend_q;
  assign mask       = mask_q;
  assign frc        = '0;
  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign bus_err    = err_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC  = IRQ_NSRC,
  parameter int unsigned PRIO_W = IRQ_PRIO_W,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]        active,
  input  logic [N_SRC*PRIO_W-1:0] prio_flat,
  output logic                    any,
  output logic [IDX_W-1:0]        win_idx,
  output logic [PRIO_W-1:0]       win_prio
);
  // complete binary tree stored as a heap; N_SRC must be a power of two
  localparam int unsigned NODES = 2*N_SRC - 1;
  localparam int unsigned LEAF0 = N_SRC - 1;

  logic              nv [NODES];
  logic [PRIO_W-1:0] np [NODES];
  logic [IDX_W-1:0]  ni [NODES];

  for (genvar g = 0; g < N_SRC; g++) begin : g_leaf
    assign nv[LEAF0+g] = active[g];
    assign np[LEAF0+g] = prio_flat[g*PRIO_W +: PRIO_W];
    assign ni[LEAF0+g] = IDX_W'(g);
  end

  // right subtree holds the higher source numbers: it wins on equal priority
  for (genvar k = 0; k < N_SRC-1; k++) begin : g_node
    localparam int unsigned L = 2*k + 1;
    localparam int unsigned R = 2*k + 2;
    logic take_r;
    assign take_r = nv[R] && (!nv[L] || (np[R] >= np[L]));
    assign nv[k]  = nv[L] || nv[R];
    assign np[k]  = take_r ? np[R] : np[L];
    assign ni[k]  = take_r ? ni[R] : ni[L];
  end

  assign any      = nv[0];
  assign win_idx  = ni[0];
  assign win_prio = np[0];
endmodule

// File: rtl/irq_outreg.sv
module irq_outreg
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC  = IRQ_NSRC,
  parameter int unsigned PRIO_W = IRQ_PRIO_W,
  parameter int unsigned VEC_W  = IRQ_VEC_W,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic [PRIO_W-1:0] win_prio,
  output logic [PRIO_W-1:0] level,
  output logic [VEC_W-1:0]  vector
);
  logic [PRIO_W-1:0] lvl_d, lvl_q;
  logic [VEC_W-1:0]  vec_d, vec_q;

  always_comb begin
    if (any) begin
      lvl_d = win_prio;
      vec_d = VEC_W'(IRQ_VEC_BASE) + VEC_W'(win_idx);
    end else begin
      lvl_d = '0;
      vec_d = VEC_W'(IRQ_VEC_IDLE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      vec_q <= VEC_W'(IRQ_VEC_IDLE);
    end else begin
      lvl_q <= lvl_d;
      vec_q <= vec_d;
    end
  end

  assign level  = lvl_q;
  assign vector = vec_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC  = IRQ_NSRC,
  parameter int unsigned PRIO_W = IRQ_PRIO_W,
  parameter int unsigned DATA_W = IRQ_DATA_W,
  parameter int unsigned ADDR_W = IRQ_ADDR_W,
  parameter int unsigned VEC_W  = IRQ_VEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err,
  output logic [PRIO_W-1:0] cpu_level,
  output logic [VEC_W-1:0]  cpu_vector
);
  localparam int unsigned IDX_W = $clog2(N_SRC);

  logic                    rst_sync_n;
  logic [N_SRC-1:0]        pend, mask, frc, enable, active;
  logic [N_SRC*PRIO_W-1:0] prio_flat;
  logic                    any;
  logic [IDX_W-1:0]        win_idx;
  logic [PRIO_W-1:0]       win_prio;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_regs #(
    .N_SRC(N_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .VEC_W(VEC_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req        (irq_req),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .bus_wdata  (bus_wdata),
    .cur_vec    (cpu_vector),
    .pend       (pend),
    .mask       (mask),
    .frc        (frc),
    .enable     (enable),
    .prio_flat  (prio_flat),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .bus_err    (bus_err)
  );

  assign active = (pend | frc) & enable & ~mask;

  irq_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .active    (active),
    .prio_flat (prio_flat),
    .any       (any),
    .win_idx   (win_idx),
    .win_prio  (win_prio)
  );

  irq_outreg #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .any      (any),
    .win_idx  (win_idx),
    .win_prio (win_prio),
    .level    (cpu_level),
    .vector   (cpu_vector)
  );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC  = IRQ_NSRC,
  parameter int unsigned PRIO_W = IRQ_PRIO_W,
  parameter int unsigned VEC_W  = IRQ_VEC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  active,
  input logic [PRIO_W-1:0] level,
  input logic [VEC_W-1:0]  vector,
  input logic              bus_we,
  input logic              bus_re,
  input logic              bus_rvalid,
  input logic              bus_err
);
  a_r5_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> (vector == VEC_W'(IRQ_VEC_IDLE)));

  a_r5_vector_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (level != '0) |-> (vector >= VEC_W'(IRQ_VEC_BASE)));

  a_r2_none_active_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |=> (level == '0));

  a_r2_active_drives_level: assert property (@(posedge clk) disable iff (!rst_n)
    (active != '0) |=> (level != '0));

  a_r8_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_we));

  a_r11_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_re));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .N_SRC(N_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .active     (active),
  .level      (cpu_level),
  .vector     (cpu_vector),
  .bus_we     (bus_we),
  .bus_re     (bus_re),
  .bus_rvalid (bus_rvalid),
  .bus_err    (bus_err)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] irq_req;
  logic [7:0]  bus_addr;
  logic        bus_we, bus_re;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, bus_err;
  logic [7:0]  cpu_level, cpu_vector;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] q_exp [$];
  string       q_tag [$];

  always #5 clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .bus_err(bus_err), .cpu_level(cpu_level), .cpu_vector(cpu_vector)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: issue a read and push its expected data to the scoreboard
  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    bus_addr = a;
    bus_re   = 1'b1;
    q_exp.push_back(e);
    q_tag.push_back(tag);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d,
                    input bit exp_err, input string tag);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    check(bus_err == exp_err, tag, 32'(bus_err), 32'(exp_err));
  endtask

  task automatic expect_out(input logic [7:0] lvl, input logic [7:0] vec,
                            input string tag);
    check(cpu_level == lvl, {tag, " level"}, 32'(cpu_level), 32'(lvl));
    check(cpu_vector == vec, {tag, " vector"}, 32'(cpu_vector), 32'(vec));
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  // monitor: pop and compare as read data returns
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (q_exp.size() == 0) begin
        check(1'b0, "R11 rvalid without read", 32'd1, 32'd0);
      end else begin
        logic [31:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check(bus_rdata == e, t, bus_rdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_req = '0; bus_addr = '0;
    bus_we = 1'b0; bus_re = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    expect_out(8'd0, 8'd24, "R12 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    expect_out(8'd0, 8'd24, "R12 after reset");
    rd(8'h08, 32'hFFFF_FFFF, "R12 mask hi reset");
    rd(8'h0C, 32'hFFFF_FFFF, "R12 mask lo reset");
    rd(8'h04, 32'h0, "R12 pending reset");
    rd(8'h45, 32'h0, "R12 prio reset");
    rd(8'hE0, 32'd24, "R10 swack idle");

    // R1 pending follows inputs
    irq_req[5] = 1'b1; irq_req[40] = 1'b1;
    @(negedge clk);
    rd(8'h04, 32'h0000_0020, "R1 pending lo");
    rd(8'h00, 32'h0000_0100, "R1 pending hi");

    // R2 disabled and masked sources stay silent
    wr(8'h45, 32'd3, 1'b0, "R3 prio write no err");
    settle();
    expect_out(8'd0, 8'd24, "R2 masked source");
    wr(8'h0C, 32'hFFFF_FFDF, 1'b0, "R7 mask lo write");
    expect_out(8'd0, 8'd24, "R13 not yet updated");
    @(negedge clk);
    expect_out(8'd3, 8'd69, "R13 R5 R6 one edge after write");

    // R4 tie goes to higher source
    wr(8'h68, 32'd3, 1'b0, "R3 prio40 write");
    wr(8'h08, 32'hFFFF_FEFF, 1'b0, "R7 mask hi write");
    settle();
    expect_out(8'd3, 8'd104, "R4 tie higher index");
    wr(8'h45, 32'd7, 1'b0, "R3 prio5 raise");
    settle();
    expect_out(8'd7, 8'd69, "R4 larger priority");
    rd(8'hE0, 32'd69, "R10 swack vector");

    // R3 zero disables
    wr(8'h45, 32'd0, 1'b0, "R3 prio5 clear");
    settle();
    expect_out(8'd3, 8'd104, "R3 disabled source drops");
    rd(8'h45, 32'd0, "R3 readback zero");
    rd(8'h68, 32'd3, "R3 readback prio40");

    // R7 halves independent
    rd(8'h08, 32'hFFFF_FEFF, "R7 mask hi readback");
    rd(8'h0C, 32'hFFFF_FFDF, "R7 mask lo readback");

    // R8 R9 ignored writes and unmapped reads
    wr(8'h04, 32'h0, 1'b0, "R8 pending write no err");
    rd(8'h00, 32'h0000_0100, "R8 pending unchanged");
    wr(8'h10, 32'hFFFF_FFFF, 1'b1, "R8 force write err");
    check(1'b1, "R8", 32'd0, 32'd0);
    @(negedge clk);
    check(bus_err == 1'b0, "R8 err single cycle", 32'(bus_err), 32'd0);
    rd(8'h10, 32'h0, "R9 force hi reads zero");
    rd(8'h14, 32'h0, "R9 force lo reads zero");
    wr(8'hE0, 32'h55, 1'b1, "R8 swack write err");
    wr(8'h30, 32'h1234, 1'b1, "R8 unmapped write err");
    rd(8'h30, 32'h0, "R9 unmapped read");
    settle();
    expect_out(8'd3, 8'd104, "R8 outputs unchanged by ignored writes");

    // R2 mask blocks
    wr(8'h08, 32'hFFFF_FFFF, 1'b0, "R7 mask hi all");
    settle();
    expect_out(8'd0, 8'd24, "R2 masked winner gone");

    // R1 level following on source 5
    irq_req[5] = 1'b0;
    wr(8'h45, 32'd9, 1'b0, "R3 prio5 nine");
    settle();
    expect_out(8'd0, 8'd24, "R1 low input inactive");
    irq_req[5] = 1'b1;
    @(negedge clk);
    expect_out(8'd0, 8'd24, "R13 input not yet seen");
    @(negedge clk);
    expect_out(8'd9, 8'd69, "R13 R1 input high");
    irq_req[5] = 1'b0;
    settle();
    expect_out(8'd0, 8'd24, "R1 input low again");

    // R4 R5 range ends
    wr(8'h40, 32'hFF, 1'b0, "R3 prio0");
    wr(8'h7F, 32'hFF, 1'b0, "R3 prio63");
    wr(8'h08, 32'h0, 1'b0, "R7 unmask hi");
    wr(8'h0C, 32'h0, 1'b0, "R7 unmask lo");
    irq_req[0] = 1'b1; irq_req[63] = 1'b1;
    settle();
    expect_out(8'hFF, 8'd127, "R4 R5 source 63 wins tie");
    rd(8'h00, 32'h8000_0100, "R1 pending hi ends");
    rd(8'h04, 32'h0000_0001, "R1 pending lo ends");
    wr(8'h7F, 32'hFE, 1'b0, "R3 prio63 lower");
    settle();
    expect_out(8'hFF, 8'd64, "R4 R5 source 0 wins");
    rd(8'hE0, 32'd64, "R10 swack source 0");

    // R12 reset mid-run
    rst_n = 1'b0;
    #1;
    expect_out(8'd0, 8'd24, "R12 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    irq_req = '0;
    repeat (3) @(negedge clk);
    rd(8'h08, 32'hFFFF_FFFF, "R12 mask hi after reset");
    rd(8'h40, 32'h0, "R12 prio0 after reset");
    expect_out(8'd0, 8'd24, "R12 outputs after reset");

    repeat (3) @(negedge clk);
    check(q_exp.size() == 0, "R11 all reads returned",
          32'(q_exp.size()), 32'd0);
    check(bus_rvalid == 1'b0, "R11 rvalid idle", 32'(bus_rvalid), 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule